// File: doc/BRIEF.md
# Multiplier-Based Parity Unit

This combinational block returns the even/odd parity of an N-bit word. It does not use an XOR tree. Instead it reduces the parity question to one unsigned binary multiplication of two operands that are built by wiring alone.

The first operand places data bit k at bit k·S, where the stride S = P + 1 and the padding width P = ceil(log2 N). Every position between data bits holds zero. The second operand has the same width, W = (N-1)·S + 1, and has a one at each data position and a zero everywhere else.

Column (N-1)·S of their product collects exactly one term from every data bit. The zero padding soaks up every carry rising from the lower columns, so that single product bit is the parity. A debug port exposes the whole 2W-bit product. A parameter selects between a shift-and-add array multiplier and the language's multiply operator.

Top module: `parity_mul`

## Requirements
- R1: With N = 8, `parity_o` equals the XOR of all bits of `data_i` for every one of the 256 input values.
- R2: With N = 5, which is not a power of two, the padding is ceil(log2 5) = 3 and `parity_o` still equals the XOR parity for all 32 input values.
- R3: With N = 24 (padding 5, stride 6), `parity_o` equals the XOR parity for arbitrary input words.
- R4: When DEBUG_EN = 1, `product_o` equals y·z, where y holds `data_i[k]` at bit k·(P+1) with zeros elsewhere, and z holds ones at those same bits and zeros elsewhere. Both are W-bit unsigned numbers.
- R5: `product_o[0]` always equals `data_i[0]`, and an all-zero input gives an all-zero product and `parity_o` = 0.
- R6: A one-hot input gives a product with exactly N bits set.
- R7: An all-ones input gives `parity_o` = N mod 2. This is the worst case for carries into the tap column: 0 for N = 8 and N = 24, 1 for N = 5.
- R8: The array multiplier (USE_OPERATOR = 0) and the operator form (USE_OPERATOR = 1) produce identical `product_o` and `parity_o` for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N | Word whose parity is taken |
| parity_o | output | 1 | 1 when an odd number of `data_i` bits are set |
| product_o | output | 2·W | Full product of the spread and mask operands when DEBUG_EN = 1, otherwise zero |

## Verification
The key corner is the all-ones word. It drives the largest column sums into the padding, so a design with too little padding, or with the tap placed one column off, reports the wrong parity there while still looking right on sparse inputs. N = 5 is covered because truncating log2 instead of rounding up leaves the padding one bit short. One-hot words and the full-product comparison catch a stride or bit-order mistake: such a mistake scatters product bits to the wrong positions even when the tapped bit happens to be correct. Running both multiplier forms on the same words exposes a wrong shift or a dropped partial product in the array.

// File: rtl/parity_mul_pkg.sv
package parity_mul_pkg;
  function automatic int pad_w(input int n);
    return $clog2(n);
  endfunction

  function automatic int stride(input int n);
    return pad_w(n) + 1;
  endfunction

  // operand width: data bits plus padding between neighbours
  function automatic int op_w(input int n);
    return (n - 1) * stride(n) + 1;
  endfunction

  function automatic int tap(input int n);
    return (n - 1) * stride(n);
  endfunction
endpackage

// File: rtl/parity_spread.sv
module parity_spread #(
  parameter int N = 8,
  localparam int S = parity_mul_pkg::stride(N),
  localparam int W = parity_mul_pkg::op_w(N)
) (
  input  logic [N-1:0] data_i,
  output logic [W-1:0] spread_o
);
  always_comb begin
    spread_o = '0;
    for (int k = 0; k < N; k++) spread_o[k*S] = data_i[k];
  end
endmodule

// File: rtl/parity_mask.sv
module parity_mask #(
  parameter int N = 8,
  localparam int S = parity_mul_pkg::stride(N),
  localparam int W = parity_mul_pkg::op_w(N)
) (
  output logic [W-1:0] mask_o
);
  always_comb begin
    mask_o = '0;
    for (int k = 0; k < N; k++) mask_o[k*S] = 1'b1;
  end
endmodule

// File: rtl/parity_umul.sv
module parity_umul #(
  parameter int W            = 8,
  parameter bit USE_OPERATOR = 1'b0,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] p_o
);
  logic [PW-1:0] b_ext;
  assign b_ext = {{W{1'b0}}, b_i};

  if (USE_OPERATOR) begin : g_op
    assign p_o = {{W{1'b0}}, a_i} * b_ext;
  end else begin : g_arr
    for (genvar k = 0; k < W; k++) begin : g_row
      logic [PW-1:0] pp;
      logic [PW-1:0] sum;
      assign pp = a_i[k] ? (b_ext << k) : '0;
      if (k == 0) begin : g_first
        assign sum = pp;
      end else begin : g_next
        assign sum = g_row[k-1].sum + pp;
      end
    end
    assign p_o = g_row[W-1].sum;
  end
endmodule

// File: rtl/parity_mul.sv
module parity_mul #(
  parameter int N            = 8,
  parameter bit USE_OPERATOR = 1'b0,
  parameter bit DEBUG_EN     = 1'b1,
  localparam int W   = parity_mul_pkg::op_w(N),
  localparam int PW  = 2 * W,
  localparam int TAP = parity_mul_pkg::tap(N)
) (
  input  logic [N-1:0]  data_i,
  output logic          parity_o,
  output logic [PW-1:0] product_o
);
  logic [W-1:0]  spread;
  logic [W-1:0]  mask;
  logic [PW-1:0] product;

  parity_spread #(.N(N)) u_spread (.data_i(data_i), .spread_o(spread));
  parity_mask   #(.N(N)) u_mask   (.mask_o(mask));

  parity_umul #(.W(W), .USE_OPERATOR(USE_OPERATOR)) u_mul (
    .a_i(spread),
    .b_i(mask),
    .p_o(product)
  );

  // padding keeps lower-column carries out of the tap column
  assign parity_o = product[TAP];

  if (DEBUG_EN) begin : g_dbg
    assign product_o = product;
  end else begin : g_nodbg
    assign product_o = '0;
  end
endmodule

// File: rtl/parity_mul_chk.sv
module parity_mul_chk #(
  parameter int N        = 8,
  parameter bit DEBUG_EN = 1'b1,
  localparam int PW = 2 * parity_mul_pkg::op_w(N)
) (
  input logic [N-1:0]  data_i,
  input logic          parity_o,
  input logic [PW-1:0] product_o
);
  always_comb begin
    if (!$isunknown(data_i)) begin
      AST_PARITY_XOR: assert (parity_o == ^data_i);  // R1
      if (data_i == '0) begin
        AST_ZERO_IN_ZERO_OUT: assert (!parity_o && product_o == '0);  // R5
      end
      if (DEBUG_EN) begin
        AST_LSB_FOLLOWS: assert (product_o[0] == data_i[0]);  // R5
        if ($onehot(data_i)) begin
          AST_ONEHOT_SPREAD: assert ($countones(product_o) == N);  // R6
        end
      end
    end
  end
endmodule

bind parity_mul parity_mul_chk #(.N(N), .DEBUG_EN(DEBUG_EN)) u_chk (
  .data_i(data_i),
  .parity_o(parity_o),
  .product_o(product_o)
);

// File: tb/parity_mul_test.sv
module parity_mul_test;
  localparam int PW8  = 2 * parity_mul_pkg::op_w(8);
  localparam int PW5  = 2 * parity_mul_pkg::op_w(5);
  localparam int PW24 = 2 * parity_mul_pkg::op_w(24);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;

  logic [7:0]      d8  = '0;
  logic [4:0]      d5  = '0;
  logic [23:0]     d24 = '0;
  logic            par8, par8op, par5, par24;
  logic [PW8-1:0]  prod8, prod8op;
  logic [PW5-1:0]  prod5;
  logic [PW24-1:0] prod24;

  parity_mul #(.N(8), .USE_OPERATOR(1'b0)) uut (
    .data_i(d8), .parity_o(par8), .product_o(prod8));
  parity_mul #(.N(8), .USE_OPERATOR(1'b1)) uut_op (
    .data_i(d8), .parity_o(par8op), .product_o(prod8op));
  parity_mul #(.N(5)) uut_odd (
    .data_i(d5), .parity_o(par5), .product_o(prod5));
  parity_mul #(.N(24)) uut_wide (
    .data_i(d24), .parity_o(par24), .product_o(prod24));

  // y*z built from the requirement, independent of the RTL
  function automatic logic [511:0] exp_prod(input int n, input logic [63:0] d);
    logic [511:0] y = '0;
    logic [511:0] z = '0;
    int s = $clog2(n) + 1;
    for (int k = 0; k < n; k++) begin
      y[k*s] = d[k];
      z[k*s] = 1'b1;
    end
    return y * z;
  endfunction

  function automatic logic exp_par(input int n, input logic [63:0] d);
    logic p = 1'b0;
    for (int k = 0; k < n; k++) p ^= d[k];
    return p;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply8(input logic [7:0] v);
    @(posedge clk); d8 = v;
    @(negedge clk);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    check("R5 zero parity", 512'(par8), 512'(0));
    check("R5 zero product", 512'(prod8), 512'(0));
  endtask

  task automatic test_full_n8();
    for (int v = 0; v < 256; v++) begin
      apply8(8'(v));
      check("R1 parity", 512'(par8), 512'(exp_par(8, 64'(v))));
      check("R4 product", 512'(prod8), exp_prod(8, 64'(v)));
      check("R5 lsb", 512'(prod8[0]), 512'(d8[0]));
      check("R8 arch product", 512'(prod8op), 512'(prod8));
      check("R8 arch parity", 512'(par8op), 512'(par8));
    end
  endtask

  task automatic test_onehot_n8();
    for (int k = 0; k < 8; k++) begin
      apply8(8'(1) << k);
      check("R6 onehot ones", 512'($countones(prod8)), 512'(8));
    end
  endtask

  task automatic test_full_n5();
    for (int v = 0; v < 32; v++) begin
      @(posedge clk); d5 = 5'(v);
      @(negedge clk);
      check("R2 parity", 512'(par5), 512'(exp_par(5, 64'(v))));
      check("R2 product", 512'(prod5), exp_prod(5, 64'(v)));
    end
  endtask

  task automatic test_all_ones();
    apply8('1);
    check("R7 all ones n8", 512'(par8), 512'(0));
    @(posedge clk); d5 = '1; d24 = '1;
    @(negedge clk);
    check("R7 all ones n5", 512'(par5), 512'(1));
    check("R7 all ones n24", 512'(par24), 512'(0));
  endtask

  task automatic test_random_n24();
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); d24 = 24'($urandom);
      @(negedge clk);
      check("R3 parity", 512'(par24), 512'(exp_par(24, 64'(d24))));
      check("R3 product", 512'(prod24), exp_prod(24, 64'(d24)));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    test_reset_state();
    test_full_n8();
    test_onehot_n8();
    test_full_n5();
    test_all_ones();
    test_random_n24();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule